// File: doc/BRIEF.md
# Polled and Interrupt-Capable Keyboard Input Port

This block sits on a 16-bit processor bus and receives characters from a keyboard-side source. The source presents an 8-bit code with a one-cycle strobe. The port captures that code, raises a ready flag and, if software has allowed it, requests an interrupt. Software then either polls the status word until the ready flag appears, or services the interrupt. In both cases it reads the character from the data word. That read is the only event that re-arms the port for the next keystroke.

The port answers two fixed bus addresses. The status word is at 16'hFE00 and the character word is at 16'hFE02. Whenever a bus read targets one of these addresses, the port raises a select output. That output tells the processor's memory data path to take the port's read data instead of RAM. While a captured character is waiting, the port accepts no new keystrokes and does not queue them; they are lost.

Top module: `kbd_input_port`

## Requirements
- R1: After reset, the ready flag, the interrupt enable and the stored character are all zero. A status read returns 16'h0000, a data read returns 16'h0000, and irq is low.
- R2: A read at address 16'hFE02 returns the stored character in bits [7:0], with bits [15:8] equal to zero.
- R3: A key_strobe that arrives while the ready flag is 0 stores key_code at the clock edge and sets the ready flag (status bit 15) from the next cycle.
- R4: A key_strobe that arrives while the ready flag is 1 is discarded and the stored character is unchanged. This also holds when a read of 16'hFE02 happens in the same cycle.
- R5: A read at address 16'hFE02 clears the ready flag from the next cycle, so that the next key_strobe is accepted.
- R6: A write at address 16'hFE00 updates only the interrupt enable, taken from write data bit 14. Write data bit 15 and the other bits have no effect. A write at address 16'hFE02 has no effect.
- R7: irq is high exactly when the ready flag and the interrupt enable are both 1.
- R8: io_sel is high only while bus_rd is high and bus_addr is 16'hFE00 or 16'hFE02. In all other cycles bus_rdata is 16'h0000.
- R9: A read at address 16'hFE00 returns the ready flag in bit 15, the interrupt enable in bit 14, and zero in bits [13:0].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| key_strobe | input | 1 | One-cycle pulse: a new character is present |
| key_code | input | 8 | Character code from the keyboard side |
| bus_addr | input | 16 | Processor bus address |
| bus_rd | input | 1 | Bus read strobe |
| bus_wr | input | 1 | Bus write strobe |
| bus_wdata | input | 16 | Bus write data |
| bus_rdata | output | 16 | Read data from the port, valid when io_sel is high |
| io_sel | output | 1 | Memory data path takes bus_rdata instead of RAM |
| irq | output | 1 | Interrupt request to the processor |

## Verification
Directed sequences cover the capture-and-read handshake in several orders. In one, a keystroke arrives while a character is still waiting; the bench checks that it is dropped and that the older code survives. In another, a keystroke coincides with the data read that would re-arm the port; this shows that the drop decision uses the ready flag before the read takes effect. Writes of all-ones patterns to the status word show whether bit 15 or the unused bits can be forced by software. Writes to the data word show whether they reach the stored character. A long random mix follows: strobes, reads and writes to both port addresses, to a neighbouring address and to random addresses. It tells apart errors in address decode, in the select output and in the interrupt gating, because each cycle is compared against the bench's own model.

// File: rtl/kbd_pkg.sv
package kbd_pkg;
  localparam int unsigned KBD_ADDR_W = 16;
  localparam int unsigned KBD_WORD_W = 16;
  localparam int unsigned KBD_CHAR_W = 8;
  localparam logic [KBD_ADDR_W-1:0] KBD_STATUS_ADDR = 16'hFE00;
  localparam logic [KBD_ADDR_W-1:0] KBD_DATA_ADDR   = 16'hFE02;
  localparam int unsigned KBD_READY_BIT = 15;
  localparam int unsigned KBD_IE_BIT    = 14;

  typedef enum logic [1:0] {
    RSEL_NONE   = 2'd0,
    RSEL_STATUS = 2'd1,
    RSEL_DATA   = 2'd2
  } rd_sel_e;
endpackage

// File: rtl/kbd_addr_decode.sv
module kbd_addr_decode
  import kbd_pkg::*;
#(
  parameter int unsigned ADDR_W = KBD_ADDR_W,
  parameter logic [ADDR_W-1:0] STATUS_ADDR = KBD_STATUS_ADDR,
  parameter logic [ADDR_W-1:0] DATA_ADDR   = KBD_DATA_ADDR
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd,
  input  logic              wr,
  output logic              stat_rd,
  output logic              data_rd,
  output logic              stat_wr,
  output rd_sel_e           rd_sel
);
  logic hit_stat;
  logic hit_data;

  assign hit_stat = (addr == STATUS_ADDR);
  assign hit_data = (addr == DATA_ADDR);

  assign stat_rd = rd & hit_stat;
  assign data_rd = rd & hit_data;
  assign stat_wr = wr & hit_stat;

  always_comb begin
    if (stat_rd)      rd_sel = RSEL_STATUS;
    else if (data_rd) rd_sel = RSEL_DATA;
    else              rd_sel = RSEL_NONE;
  end
endmodule

// File: rtl/kbd_char_latch.sv
module kbd_char_latch #(
  parameter int unsigned CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              key_strobe,
  input  logic [CHAR_W-1:0] key_code,
  input  logic              data_rd,
  output logic              ready,
  output logic [CHAR_W-1:0] char_q,
  output logic              key_accept,
  output logic              key_drop
);
  // A strobe is judged against the flag as it stands before this edge.
  assign key_accept = key_strobe & ~ready;
  assign key_drop   = key_strobe &  ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ready  <= 1'b0;
      char_q <= '0;
    end else begin
      if (key_accept) begin
        ready  <= 1'b1;
        char_q <= key_code;
      end else if (data_rd) begin
        ready  <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/kbd_irq_ctl.sv
module kbd_irq_ctl
  import kbd_pkg::*;
#(
  parameter int unsigned WORD_W = KBD_WORD_W,
  parameter int unsigned IE_BIT = KBD_IE_BIT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stat_wr,
  input  logic [WORD_W-1:0] wdata,
  input  logic              ready,
  output logic              ie,
  output logic              irq
);
  localparam logic [WORD_W-1:0] IE_MASK = WORD_W'(1) << IE_BIT;

  logic unused_wbits;
  assign unused_wbits = ^(wdata & ~IE_MASK);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ie <= 1'b0;
    else if (stat_wr) ie <= wdata[IE_BIT];
  end

  assign irq = ready & ie;
endmodule

// File: rtl/kbd_input_port.sv
module kbd_input_port
  import kbd_pkg::*;
#(
  parameter int unsigned ADDR_W = KBD_ADDR_W,
  parameter int unsigned WORD_W = KBD_WORD_W,
  parameter int unsigned CHAR_W = KBD_CHAR_W,
  parameter logic [ADDR_W-1:0] STATUS_ADDR = KBD_STATUS_ADDR,
  parameter logic [ADDR_W-1:0] DATA_ADDR   = KBD_DATA_ADDR,
  parameter int unsigned READY_BIT = KBD_READY_BIT,
  parameter int unsigned IE_BIT    = KBD_IE_BIT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              key_strobe,
  input  logic [CHAR_W-1:0] key_code,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic [WORD_W-1:0] bus_rdata,
  output logic              io_sel,
  output logic              irq
);
  function automatic logic [WORD_W-1:0] pack_status(input logic rdy, input logic en);
    logic [WORD_W-1:0] w;
    w = '0;
    w[READY_BIT] = rdy;
    w[IE_BIT]    = en;
    return w;
  endfunction

  function automatic logic [WORD_W-1:0] pack_char(input logic [CHAR_W-1:0] c);
    return {{(WORD_W-CHAR_W){1'b0}}, c};
  endfunction

  logic              stat_rd;
  logic              data_rd;
  logic              stat_wr;
  rd_sel_e           rd_sel;
  logic              ready;
  logic              ie;
  logic [CHAR_W-1:0] char_q;
  logic              key_accept;
  logic              key_drop;

  kbd_addr_decode #(
    .ADDR_W(ADDR_W), .STATUS_ADDR(STATUS_ADDR), .DATA_ADDR(DATA_ADDR)
  ) u_dec (
    .addr(bus_addr), .rd(bus_rd), .wr(bus_wr),
    .stat_rd(stat_rd), .data_rd(data_rd), .stat_wr(stat_wr), .rd_sel(rd_sel)
  );

  kbd_char_latch #(.CHAR_W(CHAR_W)) u_latch (
    .clk(clk), .rst_n(rst_n), .key_strobe(key_strobe), .key_code(key_code),
    .data_rd(data_rd), .ready(ready), .char_q(char_q),
    .key_accept(key_accept), .key_drop(key_drop)
  );

  kbd_irq_ctl #(.WORD_W(WORD_W), .IE_BIT(IE_BIT)) u_irq (
    .clk(clk), .rst_n(rst_n), .stat_wr(stat_wr), .wdata(bus_wdata),
    .ready(ready), .ie(ie), .irq(irq)
  );

  always_comb begin
    unique case (rd_sel)
      RSEL_STATUS: bus_rdata = pack_status(ready, ie);
      RSEL_DATA:   bus_rdata = pack_char(char_q);
      default:     bus_rdata = '0;
    endcase
  end

  assign io_sel = stat_rd | data_rd;
endmodule

// File: rtl/kbd_input_port_chk.sv
module kbd_input_port_chk #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned WORD_W = 16,
  parameter int unsigned CHAR_W = 8,
  parameter logic [ADDR_W-1:0] DATA_ADDR = 16'hFE02,
  parameter int unsigned IE_BIT = 14
) (
  input logic              clk,
  input logic              rst_n,
  input logic              key_strobe,
  input logic [CHAR_W-1:0] key_code,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_rd,
  input logic              stat_wr,
  input logic              data_rd,
  input logic [WORD_W-1:0] bus_wdata,
  input logic [WORD_W-1:0] bus_rdata,
  input logic              io_sel,
  input logic              irq,
  input logic              ready,
  input logic              ie,
  input logic [CHAR_W-1:0] char_q,
  input logic              key_drop
);
  AST_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    key_strobe && !ready |=> ready && char_q == $past(key_code)); // R3

  AST_DROP_KEEPS_CHAR: assert property (@(posedge clk) disable iff (!rst_n)
    key_drop |=> $stable(char_q)); // R4

  AST_DROP_ON_REARM: assert property (@(posedge clk) disable iff (!rst_n)
    key_strobe && ready && data_rd |=> !ready); // R4

  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    data_rd && ready |=> !ready && !irq); // R5

  AST_IE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    stat_wr |=> ie == $past(bus_wdata[IE_BIT])); // R6

  AST_IRQ_NEEDS_IE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ie && ready); // R7

  AST_SEL_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
    io_sel |-> bus_rd); // R8

  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    io_sel && bus_addr == DATA_ADDR |-> bus_rdata[WORD_W-1:CHAR_W] == '0); // R2
endmodule

bind kbd_input_port kbd_input_port_chk #(
  .ADDR_W(ADDR_W), .WORD_W(WORD_W), .CHAR_W(CHAR_W),
  .DATA_ADDR(DATA_ADDR), .IE_BIT(IE_BIT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .key_strobe(key_strobe), .key_code(key_code),
  .bus_addr(bus_addr), .bus_rd(bus_rd), .stat_wr(stat_wr), .data_rd(data_rd),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .io_sel(io_sel), .irq(irq),
  .ready(ready), .ie(ie), .char_q(char_q), .key_drop(key_drop)
);

// File: tb/kbd_input_port_test.sv
module kbd_input_port_test;
  localparam logic [15:0] A_STAT = 16'hFE00;
  localparam logic [15:0] A_DATA = 16'hFE02;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        key_strobe = 1'b0;
  logic [7:0]  key_code = '0;
  logic [15:0] bus_addr = '0;
  logic        bus_rd = 1'b0;
  logic        bus_wr = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        io_sel;
  logic        irq;

  int checks = 0;
  int errors = 0;

  // bench model
  logic       m_ready = 1'b0;
  logic       m_ie = 1'b0;
  logic [7:0] m_char = '0;

  always #2 clk = ~clk;

  kbd_input_port uut (
    .clk(clk), .rst_n(rst_n), .key_strobe(key_strobe), .key_code(key_code),
    .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .io_sel(io_sel), .irq(irq)
  );

  function automatic logic [15:0] want_rdata(input logic [15:0] a, input logic rd);
    if (rd && a == A_STAT) return {m_ready, m_ie, 14'b0};
    if (rd && a == A_DATA) return {8'h00, m_char};
    return 16'h0000;
  endfunction

  function automatic logic want_sel(input logic [15:0] a, input logic rd);
    return rd && (a == A_STAT || a == A_DATA);
  endfunction

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // One bus cycle: drive at negedge, check outputs, then update model at posedge.
  task automatic cycle(input logic stb, input logic [7:0] code, input logic [15:0] a,
                       input logic rd, input logic wr, input logic [15:0] wd,
                       input string tag);
    string t;
    @(negedge clk);
    key_strobe = stb; key_code = code; bus_addr = a;
    bus_rd = rd; bus_wr = wr; bus_wdata = wd;
    #1;
    if (tag != "") t = tag;
    else if (rd && a == A_STAT) t = "R9";
    else if (rd && a == A_DATA) t = "R2";
    else t = "R8";
    check(t, bus_rdata, want_rdata(a, rd));
    check("R8 io_sel", 16'(io_sel), 16'(want_sel(a, rd)));
    check("R7 irq", 16'(irq), 16'(m_ready & m_ie));
    @(posedge clk);
    if (stb && !m_ready) begin
      m_ready = 1'b1; m_char = code;
    end else if (rd && a == A_DATA) begin
      m_ready = 1'b0;
    end
    if (wr && a == A_STAT) m_ie = wd[14];
  endtask

  task automatic idle();
    cycle(1'b0, 8'h00, 16'h0000, 1'b0, 1'b0, 16'h0000, "");
  endtask

  initial begin
    #(4 * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // R1 reset state
    cycle(0, 8'h00, A_STAT, 1, 0, 16'h0, "R1 status");
    cycle(0, 8'h00, A_DATA, 1, 0, 16'h0, "R1 data");

    // R3 capture, then R4 drop while ready
    cycle(1, 8'h41, 16'h0, 0, 0, 16'h0, "");
    cycle(0, 8'h00, A_STAT, 1, 0, 16'h0, "R3 ready set");
    cycle(1, 8'h5A, 16'h0, 0, 0, 16'h0, "");
    cycle(0, 8'h00, A_DATA, 1, 0, 16'h0, "R4 old char kept");
    // R5 read cleared the flag
    cycle(0, 8'h00, A_STAT, 1, 0, 16'h0, "R5 ready cleared");
    // R4 strobe coincides with re-arm read: dropped
    cycle(1, 8'h42, 16'h0, 0, 0, 16'h0, "");
    cycle(1, 8'h77, A_DATA, 1, 0, 16'h0, "R4 read during strobe");
    cycle(0, 8'h00, A_STAT, 1, 0, 16'h0, "R4 flag clear after coincident");
    cycle(0, 8'h00, A_DATA, 1, 0, 16'h0, "R4 char not replaced");

    // R6 status write only touches bit 14; data write ignored
    cycle(0, 8'h00, A_STAT, 0, 1, 16'hBFFF, "");
    cycle(0, 8'h00, A_STAT, 1, 0, 16'h0, "R6 bit15 not writable");
    cycle(0, 8'h00, A_STAT, 0, 1, 16'hFFFF, "");
    cycle(0, 8'h00, A_STAT, 1, 0, 16'h0, "R6 only ie set");
    cycle(0, 8'h00, A_DATA, 0, 1, 16'h00EE, "");
    cycle(0, 8'h00, A_DATA, 1, 0, 16'h0, "R6 data write ignored");

    // R7 irq with ie set
    cycle(1, 8'h0D, 16'h0, 0, 0, 16'h0, "");
    idle();
    cycle(0, 8'h00, A_DATA, 1, 0, 16'h0, "R2 read with irq");
    idle();
    // R8 neighbour address
    cycle(0, 8'h00, 16'hFE04, 1, 0, 16'h0, "R8 neighbour");

    // random mix
    for (int i = 0; i < 2000; i++) begin
      logic [15:0] a;
      logic [1:0]  op;
      int unsigned pick;
      pick = $urandom_range(0, 3);
      case (pick)
        0: a = A_STAT;
        1: a = A_DATA;
        2: a = 16'hFE04;
        default: a = 16'($urandom);
      endcase
      op = 2'($urandom_range(0, 3));
      cycle(1'($urandom_range(0, 2) == 0), 8'($urandom), a,
            op == 2'd1, op == 2'd2, 16'($urandom), "");
    end

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule